// File: doc/BRIEF.md
# Four-Channel Single-Byte Peripheral-to-Memory DMA Controller

This block moves bytes from I/O peripherals into memory on their behalf. Each of four channels has a request input and an acknowledge output. Each channel also holds a 16-bit target address, a byte count and an enable mask. Software loads these through a small write-only configuration port. When an enabled channel with a non-zero count raises its request, the controller asks the host processor for the bus and waits for the grant.

With the bus granted, the controller serves the highest-priority pending channel. It drives that channel's address, raises the memory-write and I/O-read strobes together with that channel's acknowledge, and holds the strobes while the peripheral pulls `ready_i` low. Each grant moves one byte, after which the address steps up and the count steps down. The controller keeps the bus while any other channel is waiting. It releases the bus only when nothing is pending.

When the last counted byte of a channel has moved, the shared end-of-process output pulses alongside that channel's acknowledge. The channel then stays idle until its count is written again. Tri-state is modelled by `bus_oe_o`, which accompanies the address and strobes.

Top module: `dma_byte_ctrl`

## Requirements
- R1: After reset, `hrq_o`, `dack_o`, `bus_oe_o`, `mem_wr_o`, `io_rd_o` and `eop_o` are all low, every channel is masked, and every count is zero.
- R2: A channel is eligible only when its request is high, its mask is clear and its count is non-zero. Requests from ineligible channels leave `hrq_o` low.
- R3: An eligible request raises `hrq_o`. `bus_oe_o`, the strobes and every acknowledge stay low until `hlda_i` is seen high.
- R4: During the strobe phase, `bus_oe_o`, `mem_wr_o` and `io_rd_o` are high, exactly the granted channel's acknowledge bit is high, and `addr_o` equals that channel's address register.
- R5: The strobes last one clock when `ready_i` is high and are held for each extra clock that `ready_i` is low.
- R6: Each grant moves one byte. After the strobes drop, the acknowledge stays high with `bus_oe_o` until the peripheral lowers its request, and it drops on the following clock.
- R7: After each byte, the channel address increments by one, wrapping 0xFFFF to 0x0000, and the count decrements by one.
- R8: On the byte that takes the count to zero, `eop_o` is high during the acknowledge-hold phase. Further requests from that channel are then ignored.
- R9: Priority is fixed, with channel 0 highest and channel 3 lowest, and it is decided when the bus is held.
- R10: When a byte finishes and another channel is eligible, the next channel is served without `hrq_o` dropping. When none is eligible, `hrq_o` and `bus_oe_o` fall together.
- R11: Configuration writes use `cfg_kind_i` codes 0 (address), 1 (count) and 2 (mask, with `cfg_wdata_i[0]` = 1 meaning masked). Code 3 is ignored. Writing a non-zero count re-arms a channel that reached terminal count, and a mask write disables or enables a channel without touching its address or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | Register select: 0 address, 1 count, 2 mask |
| cfg_chan_i | input | 2 | Channel addressed by the write |
| cfg_wdata_i | input | 16 | Write data |
| drq_i | input | 4 | Per-channel transfer requests |
| dack_o | output | 4 | Per-channel acknowledges |
| hrq_o | output | 1 | Bus request to host |
| hlda_i | input | 1 | Bus grant from host |
| ready_i | input | 1 | Peripheral ready; low inserts wait states |
| addr_o | output | 16 | Memory address |
| mem_wr_o | output | 1 | Memory write strobe (active high) |
| io_rd_o | output | 1 | I/O read strobe (active high) |
| bus_oe_o | output | 1 | Drive enable for address and strobes |
| eop_o | output | 1 | Terminal count of the active channel |

## Verification
Single requests are run with `ready_i` high and with two wait states. These separate a fixed-length strobe from one that honours the stretch, and they show the address stepping between bytes. Two channels are requested in the same cycle with the grant held. This shows both that the lower index wins and that the bus is kept across the hand-over, with the address wrapping on the low-priority channel. Masked, zero-count and post-terminal-count requests are each held for several cycles with `hrq_o` watched. A delayed grant checks that nothing is driven before `hlda_i`.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_HOLD = 2'd3
  } dma_state_e;

  localparam logic [1:0] KIND_ADDR = 2'd0;
  localparam logic [1:0] KIND_CNT  = 2'd1;
  localparam logic [1:0] KIND_MASK = 2'd2;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_addr_i,
  input  logic          wr_cnt_i,
  input  logic          wr_mask_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          armed_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mask_q <= 1'b1;
    end else begin
      if (wr_addr_i)   addr_q <= wdata_i;
      else if (step_i) addr_q <= addr_q + 1'b1;
      if (wr_cnt_i)    cnt_q  <= CW'(wdata_i);
      else if (step_i) cnt_q  <= cnt_q - 1'b1;
      if (wr_mask_i)   mask_q <= wdata_i[0];
    end
  end

  assign addr_o  = addr_q;
  assign armed_o = !mask_q && (cnt_q != '0);
  assign last_o  = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [CHW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CHW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           any_elig_i,
  input  logic [CHW-1:0] win_idx_i,
  input  logic [NCH-1:0] drq_i,
  input  logic           hlda_i,
  input  logic           ready_i,
  input  logic           last_i,
  output logic [CHW-1:0] ch_o,
  output logic           step_o,
  output logic           hrq_o,
  output logic           xfer_o,
  output logic           hold_o,
  output logic           tc_o
);
  dma_state_e     state_q;
  logic [CHW-1:0] ch_q;
  logic           tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      tc_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (any_elig_i) state_q <= ST_REQ;
        ST_REQ: begin
          if (hlda_i && any_elig_i) begin
            state_q <= ST_XFER;
            ch_q    <= win_idx_i;
          end else if (!any_elig_i) begin
            state_q <= ST_IDLE;
          end
        end
        ST_XFER: begin
          if (ready_i) begin
            state_q <= ST_HOLD;
            tc_q    <= last_i;
          end
        end
        ST_HOLD: begin
          if (!drq_i[ch_q]) begin
            tc_q <= 1'b0;
            if (any_elig_i && hlda_i) begin
              state_q <= ST_XFER;  // keep the bus for the next channel
              ch_q    <= win_idx_i;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ch_o   = ch_q;
  assign xfer_o = (state_q == ST_XFER);
  assign hold_o = (state_q == ST_HOLD);
  assign hrq_o  = (state_q != ST_IDLE);
  assign step_o = xfer_o && ready_i;
  assign tc_o   = tc_q;
endmodule

// File: rtl/dma_byte_ctrl.sv
module dma_byte_ctrl
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_wr_i,
  input  logic [1:0]     cfg_kind_i,
  input  logic [CHW-1:0] cfg_chan_i,
  input  logic [AW-1:0]  cfg_wdata_i,
  input  logic [NCH-1:0] drq_i,
  output logic [NCH-1:0] dack_o,
  output logic           hrq_o,
  input  logic           hlda_i,
  input  logic           ready_i,
  output logic [AW-1:0]  addr_o,
  output logic           mem_wr_o,
  output logic           io_rd_o,
  output logic           bus_oe_o,
  output logic           eop_o
);
  logic [AW-1:0]  ch_addr [NCH];
  logic [NCH-1:0] armed, last, elig;
  logic [CHW-1:0] win_idx, cur_ch;
  logic           any_elig, step, xfer, hold, tc;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic sel;
    assign sel = cfg_wr_i && (cfg_chan_i == CHW'(g));
    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_addr_i (sel && cfg_kind_i == KIND_ADDR),
      .wr_cnt_i  (sel && cfg_kind_i == KIND_CNT),
      .wr_mask_i (sel && cfg_kind_i == KIND_MASK),
      .wdata_i   (cfg_wdata_i),
      .step_i    (step && cur_ch == CHW'(g)),
      .addr_o    (ch_addr[g]),
      .armed_o   (armed[g]),
      .last_o    (last[g])
    );
  end

  assign elig = drq_i & armed;

  dma_prio_arb #(.NCH(NCH)) u_arb (
    .req_i (elig),
    .any_o (any_elig),
    .idx_o (win_idx)
  );

  dma_seq #(.NCH(NCH)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_elig_i (any_elig),
    .win_idx_i  (win_idx),
    .drq_i      (drq_i),
    .hlda_i     (hlda_i),
    .ready_i    (ready_i),
    .last_i     (last[cur_ch]),
    .ch_o       (cur_ch),
    .step_o     (step),
    .hrq_o      (hrq_o),
    .xfer_o     (xfer),
    .hold_o     (hold),
    .tc_o       (tc)
  );

  assign bus_oe_o = xfer || hold;
  assign mem_wr_o = xfer;
  assign io_rd_o  = xfer;
  assign addr_o   = bus_oe_o ? ch_addr[cur_ch] : '0;
  assign dack_o   = bus_oe_o ? (NCH'(1) << cur_ch) : '0;
  assign eop_o    = hold && tc;
endmodule

module dma_byte_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hrq_o,
  input logic           hlda_i,
  input logic           ready_i,
  input logic [NCH-1:0] dack_o,
  input logic           mem_wr_o,
  input logic           io_rd_o,
  input logic           bus_oe_o,
  input logic           eop_o
);
  // R3
  bus_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (hlda_i && hrq_o));
  // R4
  dack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o));
  // R4
  strobe_one_dack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o || io_rd_o) |-> ($countones(dack_o) == 1 && mem_wr_o == io_rd_o));
  // R5
  wait_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !ready_i) |=> mem_wr_o);
  // R8
  eop_with_dack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (dack_o != '0 && !mem_wr_o));
  // R10
  release_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hrq_o) |-> (dack_o == '0 && !bus_oe_o));
endmodule

bind dma_byte_ctrl dma_byte_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hrq_o    (hrq_o),
  .hlda_i   (hlda_i),
  .ready_i  (ready_i),
  .dack_o   (dack_o),
  .mem_wr_o (mem_wr_o),
  .io_rd_o  (io_rd_o),
  .bus_oe_o (bus_oe_o),
  .eop_o    (eop_o)
);

// File: tb/dma_byte_ctrl_test.sv
module dma_byte_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [1:0]  cfg_kind_i = '0;
  logic [1:0]  cfg_chan_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [3:0]  drq_i = '0;
  logic [3:0]  dack_o;
  logic        hrq_o;
  logic        hlda_i = 1'b0;
  logic        ready_i = 1'b1;
  logic [15:0] addr_o;
  logic        mem_wr_o, io_rd_o, bus_oe_o, eop_o;
  logic        hold_off = 1'b0;

  int checks = 0;
  int failures = 0;

  dma_byte_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // host model: grant follows request one half-cycle later
  initial forever begin
    @(negedge clk_i);
    hlda_i = hrq_o && !hold_off;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] kind, input logic [1:0] ch,
                           input logic [15:0] data);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_kind_i = kind; cfg_chan_i = ch; cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  task automatic idle_watch(input string req, input string what);
    repeat (5) @(negedge clk_i);
    check(hrq_o == 1'b0, req, what, hrq_o, 0);
    check(dack_o == 4'b0, req, {what, " dack"}, dack_o, 0);
  endtask

  // serve one byte; drq[ch] must already be high
  task automatic do_byte(input int ch, input logic [15:0] exp_addr,
                         input int waits, input bit exp_eop);
    bit seen = 0;
    ready_i = (waits == 0);
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk_i);
      seen = mem_wr_o && dack_o[ch];
    end
    check(seen, "R4", "strobe with dack", {31'b0, seen}, 1);
    check(addr_o == exp_addr, "R4", "address", addr_o, exp_addr);
    check(dack_o == (4'b1 << ch) && io_rd_o && bus_oe_o, "R4", "dack/io_rd/oe",
          {dack_o, io_rd_o, bus_oe_o}, {4'b1 << ch, 2'b11});
    for (int i = 0; i < waits; i++) begin
      @(negedge clk_i);
      check(mem_wr_o && io_rd_o, "R5", "strobes held in wait state", mem_wr_o, 1);
    end
    ready_i = 1'b1;
    @(negedge clk_i);
    check(!mem_wr_o && !io_rd_o, "R5", "strobes released", mem_wr_o, 0);
    check(dack_o == (4'b1 << ch) && bus_oe_o, "R6", "dack held until drq drops",
          dack_o, 4'b1 << ch);
    check(eop_o == exp_eop, "R8", "eop", eop_o, exp_eop);
    drq_i[ch] = 1'b0;
    @(negedge clk_i);
    check(dack_o[ch] == 1'b0, "R6", "dack removed", dack_o, 0);
  endtask

  task automatic t_reset;
    check(!hrq_o && dack_o == 0 && !bus_oe_o && !mem_wr_o && !io_rd_o && !eop_o,
          "R1", "reset outputs", {hrq_o, dack_o, bus_oe_o, mem_wr_o, io_rd_o, eop_o}, 0);
    drq_i = 4'hF;
    idle_watch("R1", "masked after reset");
    drq_i = 4'h0;
  endtask

  task automatic t_eligibility;
    cfg_write(2'd0, 2'd1, 16'h4000);
    cfg_write(2'd1, 2'd1, 16'd4);
    drq_i[1] = 1'b1;
    idle_watch("R2", "masked channel ignored");
    drq_i[1] = 1'b0;
    cfg_write(2'd2, 2'd2, 16'd0);
    drq_i[2] = 1'b1;
    idle_watch("R2", "zero count ignored");
    drq_i[2] = 1'b0;
    cfg_write(2'd3, 2'd1, 16'd0);
    drq_i[1] = 1'b1;
    idle_watch("R11", "kind 3 does not unmask");
    drq_i[1] = 1'b0;
  endtask

  task automatic t_single;
    cfg_write(2'd0, 2'd2, 16'h1234);
    cfg_write(2'd1, 2'd2, 16'd3);
    hold_off = 1'b1;
    drq_i[2] = 1'b1;
    repeat (4) @(negedge clk_i);
    check(hrq_o == 1'b1, "R3", "hrq raised", hrq_o, 1);
    check(!bus_oe_o && !mem_wr_o && dack_o == 0, "R3", "nothing before hlda",
          {bus_oe_o, mem_wr_o, dack_o}, 0);
    hold_off = 1'b0;
    do_byte(2, 16'h1234, 0, 0);
    check(!hrq_o && !bus_oe_o, "R10", "bus released when idle", {hrq_o, bus_oe_o}, 0);
    drq_i[2] = 1'b1;
    do_byte(2, 16'h1235, 2, 0);   // R7 address stepped
    drq_i[2] = 1'b1;
    do_byte(2, 16'h1236, 0, 1);   // R8 terminal count
    drq_i[2] = 1'b1;
    idle_watch("R8", "channel idle after terminal count");
    cfg_write(2'd1, 2'd2, 16'd1);
    do_byte(2, 16'h1237, 0, 1);   // R11 re-armed by count write
  endtask

  task automatic t_priority;
    cfg_write(2'd0, 2'd0, 16'h0100);
    cfg_write(2'd1, 2'd0, 16'd5);
    cfg_write(2'd2, 2'd0, 16'd0);
    cfg_write(2'd0, 2'd3, 16'hFFFF);
    cfg_write(2'd1, 2'd3, 16'd2);
    cfg_write(2'd2, 2'd3, 16'd0);
    @(negedge clk_i);
    drq_i = 4'b1001;
    do_byte(0, 16'h0100, 0, 0);   // R9 channel 0 first
    check(hrq_o == 1'b1, "R10", "bus kept for pending channel", hrq_o, 1);
    do_byte(3, 16'hFFFF, 1, 0);
    check(!hrq_o && !bus_oe_o, "R10", "release after last pending", {hrq_o, bus_oe_o}, 0);
    drq_i[3] = 1'b1;
    do_byte(3, 16'h0000, 0, 1);   // R7 wrap, R8 eop
    cfg_write(2'd2, 2'd0, 16'd1);
    drq_i[0] = 1'b1;
    idle_watch("R11", "mask write disables channel");
    cfg_write(2'd2, 2'd0, 16'd0);
    do_byte(0, 16'h0101, 0, 0);   // R11 mask kept address and count
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_eligibility();
    t_single();
    t_priority();
    repeat (3) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule